// File: doc/BRIEF.md
# Quad-Lane Serial OTP Read Target

This block is the target side of a serial memory link that answers one command: a read of a 64-byte one-time-programmable (OTP) area in which the opcode, the address and the returned data all travel four bits per clock on four data lines. While chip select is low it samples one nibble per rising clock edge: first the two opcode nibbles, then the address nibbles. The address is six nibbles when the 4-byte-address flag is low and eight nibbles when it is high. Next it lets a fixed run of dummy clocks pass. The four-lane bus does not shorten this run. It then turns the lines around and streams bytes out of the array, high nibble first, changing its outputs on falling edges.

Only the low six address bits pick the first byte. Later bytes come from rising addresses and wrap from 63 back to 0 for as long as the host keeps clocking. An unknown opcode leaves the lines undriven until chip select rises. Raising chip select at any point ends the transaction at once.

The array is filled through a byte-load stream port in the serial clock domain. A load transfers on a rising edge when valid and ready are both high. Ready is high only while reset is released and chip select is high, so the host holds valid and its payload until it sees ready, and a load cannot disturb a read in progress.

Top module: `qotp_target`

## Requirements
- R1: The opcode is two nibbles, high nibble first, each nibble carried with DQ3 as most significant bit and DQ0 as least; only 0x4B starts a read.
- R2: With `addr4_en` low the address is 24 bits taken in 6 rising edges, most significant nibble first.
- R3: With `addr4_en` high the address is 32 bits taken in 8 rising edges, most significant nibble first (first nibble carries A31..A28 on DQ3..DQ0).
- R4: Only address bits 5..0 select the first byte; all higher address bits are ignored.
- R5: Exactly 8 dummy rising edges follow the address; `dq_oe` stays 4'h0 through the opcode, address and dummy edges.
- R6: On the falling edge after the 8th dummy rising edge, `dq_oe` becomes 4'hF and the first data nibble is driven.
- R7: Each byte goes out over two clocks: bits 7..4 on DQ3..DQ0, then bits 3..0, each nibble changing on a falling edge.
- R8: Successive bytes come from successive addresses and wrap from byte 63 to byte 0.
- R9: Any opcode other than 0x4B keeps `dq_oe` at 4'h0 until chip select rises.
- R10: Chip select high releases `dq_oe` at once and restarts decoding at the opcode on the next transaction.
- R11: A load writes `ld_data` to byte `ld_addr` on a rising edge with `ld_valid` and `ld_ready` high; `ld_ready` is high only while chip select is high and reset is released.
- R12: While `rst_n` is low, `dq_oe` is 4'h0 and `ld_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; inputs sampled on rising edge, outputs change on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| dq_in | input | 4 | Data lines as seen by the target (DQ3..DQ0) |
| addr4_en | input | 1 | High selects 32-bit addressing, low 24-bit; steady during a transaction |
| dq_out | output | 4 | Data nibble driven toward the host |
| dq_oe | output | 4 | Per-line output enables |
| ld_valid | input | 1 | Preload byte offered |
| ld_ready | output | 1 | Preload byte may transfer |
| ld_addr | input | 6 | Preload byte index |
| ld_data | input | 8 | Preload byte value |

## Verification
The bench builds the block with its default parameters: a 64-entry array, an 8-clock dummy run and opcode 0x4B. With these, wrap-around is reached in two or three bytes from a start near 63. Both address widths run through the same vector loop. The high address bits can be loaded with values that would pick a different byte if they were decoded. Directed tests add an unknown opcode, a load attempted during a transaction, and chip select raised in the middle of the data phase.

// File: rtl/qotp_pkg.sv
package qotp_pkg;
  localparam int NIB_W = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_OPC   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DUMMY = 3'd2,
    PH_DATA  = 3'd3,
    PH_SKIP  = 3'd4
  } qotp_phase_e;
endpackage

// File: rtl/qotp_seq.sv
module qotp_seq
  import qotp_pkg::*;
#(
  parameter logic [7:0] OPCODE     = 8'h4B,
  parameter int         DUMMY_CLKS = 8,
  parameter int         PTR_W      = 6,
  parameter int         ADDR_BYTES_SHORT = 3,
  parameter int         ADDR_BYTES_LONG  = 4
) (
  input  logic              sclk,
  input  logic              rst_any,
  input  logic [NIB_W-1:0]  dq_in,
  input  logic              addr4_en,
  output qotp_phase_e       phase,
  output logic [PTR_W-1:0]  ptr,
  output logic              nib_lo
);
  localparam int CNT_MAX = (DUMMY_CLKS > 2*ADDR_BYTES_LONG) ? DUMMY_CLKS : 2*ADDR_BYTES_LONG;
  localparam int CNT_W   = $clog2(CNT_MAX) + 1;
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(2*ADDR_BYTES_SHORT - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(2*ADDR_BYTES_LONG - 1);
  localparam logic [CNT_W-1:0] LAST_DUMMY = CNT_W'(DUMMY_CLKS - 1);

  logic [CNT_W-1:0] cnt;
  logic [NIB_W-1:0] opc_hi;
  logic [CNT_W-1:0] addr_last;
  logic [PTR_W-1:0] ptr_shift;

  assign addr_last = addr4_en ? LAST_LONG : LAST_SHORT;

  generate
    if (PTR_W > NIB_W) begin : g_wide
      assign ptr_shift = {ptr[PTR_W-NIB_W-1:0], dq_in};
    end else begin : g_narrow
      assign ptr_shift = dq_in[PTR_W-1:0];
    end
  endgenerate

  always_ff @(posedge sclk or posedge rst_any) begin
    if (rst_any) begin
      phase  <= PH_OPC;
      cnt    <= '0;
      opc_hi <= '0;
      ptr    <= '0;
      nib_lo <= 1'b0;
    end else begin
      unique case (phase)
        PH_OPC: begin
          if (cnt == '0) begin
            opc_hi <= dq_in;
            cnt    <= CNT_W'(1);
          end else begin
            cnt   <= '0;
            phase <= ({opc_hi, dq_in} == OPCODE) ? PH_ADDR : PH_SKIP;
          end
        end
        PH_ADDR: begin
          ptr <= ptr_shift;
          if (cnt == addr_last) begin
            cnt   <= '0;
            phase <= PH_DUMMY;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_DUMMY: begin
          if (cnt == LAST_DUMMY) begin
            cnt    <= '0;
            nib_lo <= 1'b0;
            phase  <= PH_DATA;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_DATA: begin
          nib_lo <= ~nib_lo;
          if (nib_lo) ptr <= ptr + PTR_W'(1);
        end
        default: begin
          phase <= PH_SKIP;
        end
      endcase
    end
  end
endmodule

// File: rtl/qotp_mem.sv
module qotp_mem
  import qotp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic              sclk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] cells [DEPTH];

  always_ff @(posedge sclk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/qotp_drive.sv
module qotp_drive
  import qotp_pkg::*;
(
  input  logic              sclk,
  input  logic              rst_any,
  input  qotp_phase_e       phase,
  input  logic              nib_lo,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [NIB_W-1:0]  dq_out,
  output logic [NIB_W-1:0]  dq_oe
);
  logic [NIB_W-1:0] nib;

  assign nib = nib_lo ? rd_data[NIB_W-1:0] : rd_data[BYTE_W-1:NIB_W];

  always_ff @(negedge sclk or posedge rst_any) begin
    if (rst_any) begin
      dq_out <= '0;
      dq_oe  <= '0;
    end else begin
      dq_out <= nib;
      dq_oe  <= {NIB_W{phase == PH_DATA}};
    end
  end
endmodule

// File: rtl/qotp_target.sv
module qotp_target
  import qotp_pkg::*;
#(
  parameter int         DEPTH      = 64,
  parameter int         DUMMY_CLKS = 8,
  parameter logic [7:0] OPCODE     = 8'h4B,
  localparam int        PTR_W      = $clog2(DEPTH)
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic [3:0]       dq_in,
  input  logic             addr4_en,
  output logic [3:0]       dq_out,
  output logic [3:0]       dq_oe,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [PTR_W-1:0] ld_addr,
  input  logic [7:0]       ld_data
);
  logic              rst_any;
  qotp_phase_e       phase;
  logic [PTR_W-1:0]  ptr;
  logic              nib_lo;
  logic [BYTE_W-1:0] rd_data;

  assign rst_any  = cs_n | ~rst_n;
  assign ld_ready = cs_n & rst_n;

  qotp_seq #(
    .OPCODE(OPCODE), .DUMMY_CLKS(DUMMY_CLKS), .PTR_W(PTR_W),
    .ADDR_BYTES_SHORT(3), .ADDR_BYTES_LONG(4)
  ) u_seq (
    .sclk(sclk), .rst_any(rst_any), .dq_in(dq_in), .addr4_en(addr4_en),
    .phase(phase), .ptr(ptr), .nib_lo(nib_lo)
  );

  qotp_mem #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_mem (
    .sclk(sclk), .wr_en(ld_valid & ld_ready), .wr_addr(ld_addr),
    .wr_data(ld_data), .rd_addr(ptr), .rd_data(rd_data)
  );

  qotp_drive u_drv (
    .sclk(sclk), .rst_any(rst_any), .phase(phase), .nib_lo(nib_lo),
    .rd_data(rd_data), .dq_out(dq_out), .dq_oe(dq_oe)
  );
endmodule

// File: rtl/qotp_target_chk.sv
module qotp_target_chk #(
  parameter int         DUMMY_CLKS = 8,
  parameter logic [7:0] OPCODE     = 8'h4B
) (
  input logic       sclk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [3:0] dq_in,
  input logic       addr4_en,
  input logic [3:0] dq_oe
);
  localparam int CW = $clog2(2 + 8 + DUMMY_CLKS + 1) + 1;

  logic          rst_any;
  logic [CW-1:0] edges;
  logic [7:0]    opc_seen;
  logic          got_opc;
  logic          opc_ok;
  int            data_from;

  assign rst_any = cs_n | ~rst_n;

  always_ff @(posedge sclk or posedge rst_any) begin
    if (rst_any) begin
      edges    <= '0;
      opc_seen <= '0;
    end else begin
      if (edges == CW'(0)) opc_seen[7:4] <= dq_in;
      if (edges == CW'(1)) opc_seen[3:0] <= dq_in;
      if (edges != {CW{1'b1}}) edges <= edges + CW'(1);
    end
  end

  always_comb begin
    got_opc   = int'(edges) >= 2;
    opc_ok    = got_opc && (opc_seen == OPCODE);
    data_from = 2 + (addr4_en ? 8 : 6) + DUMMY_CLKS;
  end

  assert_quiet_before_data_R5: assert property (@(posedge sclk) disable iff (rst_any)
    (int'(edges) < data_from) |-> (dq_oe == 4'h0));

  assert_drive_after_dummy_R6: assert property (@(posedge sclk) disable iff (rst_any)
    (opc_ok && int'(edges) >= data_from) |-> (dq_oe == 4'hF));

  assert_bad_opcode_quiet_R9: assert property (@(posedge sclk) disable iff (rst_any)
    (got_opc && !opc_ok) |-> (dq_oe == 4'h0));

  assert_release_on_cs_R10: assert property (@(negedge sclk) disable iff (!rst_n)
    cs_n |-> (dq_oe == 4'h0));

  assert_reset_quiet_R12: assert property (@(posedge sclk)
    !rst_n |-> (dq_oe == 4'h0));
endmodule

bind qotp_target qotp_target_chk #(.DUMMY_CLKS(DUMMY_CLKS), .OPCODE(OPCODE)) u_chk (
  .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .dq_in(dq_in),
  .addr4_en(addr4_en), .dq_oe(dq_oe)
);

// File: tb/sim_qotp_target.sv
module sim_qotp_target;
  logic       sclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic [3:0] dq_in = 4'h0;
  logic       addr4_en = 1'b0;
  logic [3:0] dq_out;
  logic [3:0] dq_oe;
  logic       ld_valid = 1'b0;
  logic       ld_ready;
  logic [5:0] ld_addr = 6'd0;
  logic [7:0] ld_data = 8'h00;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 sclk = ~sclk;

  qotp_target u0 (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .dq_in(dq_in), .addr4_en(addr4_en),
    .dq_out(dq_out), .dq_oe(dq_oe), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data)
  );

  // opcode[47:40] address[39:8] wide-address[7] byte count[6:0]
  localparam logic [47:0] VEC [0:5] = '{
    {8'h4B, 32'h0000_0000, 1'b0, 7'd4},   // R1 R2 base read
    {8'h4B, 32'h0000_003E, 1'b0, 7'd4},   // R8 wrap
    {8'h4B, 32'hFFFF_FF05, 1'b1, 7'd3},   // R3 R4 high bits ignored
    {8'h4B, 32'h1234_567F, 1'b1, 7'd2},   // R3 R8
    {8'h4B, 32'h00AB_CD15, 1'b0, 7'd3},   // R2 R4
    {8'h03, 32'h0000_0010, 1'b0, 7'd2}    // R9 unknown opcode
  };

  function automatic logic [7:0] img(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_byte(logic [5:0] a, logic [7:0] d);
    @(negedge sclk); #1;
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge sclk); #1;
    ld_valid = 1'b0;
  endtask

  task automatic send_nib(logic [3:0] n);
    @(negedge sclk); #1;
    cs_n = 1'b0;
    dq_in = n;
  endtask

  task automatic end_txn();
    @(negedge sclk); #1;
    cs_n = 1'b1; dq_in = 4'h0;
    #1;
    chk(dq_oe == 4'h0, "R10 release on cs high", int'(dq_oe), 0);
  endtask

  task automatic start_read(logic [7:0] opc, logic [31:0] addr, logic w4);
    int an;
    addr4_en = w4;
    an = w4 ? 8 : 6;
    send_nib(opc[7:4]);
    send_nib(opc[3:0]);
    for (int i = an - 1; i >= 0; i--) begin
      send_nib(addr[4*i +: 4]);
      chk(dq_oe == 4'h0, "R5 quiet in address", int'(dq_oe), 0);
    end
    for (int d = 0; d < 8; d++) begin
      send_nib(4'h0);
      chk(dq_oe == 4'h0, "R5 quiet in dummy", int'(dq_oe), 0);
    end
    @(posedge sclk); #2;
    chk(dq_oe == 4'h0, "R5 still quiet at last dummy edge", int'(dq_oe), 0);
  endtask

  task automatic read_bytes(int start, int n, bit good, string tag);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      @(posedge sclk); #2;
      b[7:4] = dq_out;
      chk(dq_oe == (good ? 4'hF : 4'h0), {tag, " R6 R9 enables"}, int'(dq_oe), good ? 15 : 0);
      @(posedge sclk); #2;
      b[3:0] = dq_out;
      if (good)
        chk(b == img((start + k) % 64), {tag, " R7 R8 byte"}, int'(b), int'(img((start + k) % 64)));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge sclk);
    #1;
    chk(dq_oe == 4'h0, "R12 oe in reset", int'(dq_oe), 0);
    chk(ld_ready == 1'b0, "R12 ready in reset", int'(ld_ready), 0);
    rst_n = 1'b1;
    #1;
    chk(ld_ready == 1'b1, "R11 ready when idle", int'(ld_ready), 1);

    for (int i = 0; i < 64; i++) load_byte(6'(i), img(i));

    // vector walk
    for (int v = 0; v < 6; v++) begin
      logic [7:0] opc;
      logic [31:0] a;
      opc = VEC[v][47:40];
      a   = VEC[v][39:8];
      start_read(opc, a, VEC[v][7]);
      read_bytes(int'(a[5:0]), int'(VEC[v][6:0]), opc == 8'h4B, $sformatf("vec%0d", v));
      end_txn();
    end

    // R11: load offered during a transaction is not taken
    send_nib(4'hF);
    #1;
    chk(ld_ready == 1'b0, "R11 ready low in txn", int'(ld_ready), 0);
    ld_valid = 1'b1; ld_addr = 6'd0; ld_data = ~img(0);
    repeat (4) send_nib(4'h0);
    ld_valid = 1'b0;
    end_txn();
    start_read(8'h4B, 32'h0, 1'b0);
    read_bytes(0, 1, 1'b1, "R11 load blocked");
    end_txn();

    // R10: abort mid-data, then fresh decode
    start_read(8'h4B, 32'h0000_000A, 1'b0);
    read_bytes(10, 1, 1'b1, "R10 pre-abort");
    @(posedge sclk); #2;
    chk(dq_oe == 4'hF, "R10 driving before abort", int'(dq_oe), 15);
    cs_n = 1'b1;
    #1;
    chk(dq_oe == 4'h0, "R10 immediate release", int'(dq_oe), 0);
    start_read(8'h4B, 32'h0000_0014, 1'b1);
    read_bytes(20, 2, 1'b1, "R10 restart");
    end_txn();

    // R8: full lap from 60
    start_read(8'h4B, 32'h0000_003C, 1'b0);
    read_bytes(60, 70, 1'b1, "R8 lap");
    end_txn();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule